// File: doc/BRIEF.md
# Compensated nanosecond time counter

This block keeps a free-running 64-bit time value in nanoseconds. On every enabled tick of its clock it adds a small per-tick increment. Normally this is the default step, which matches the clock period in nanoseconds. Two frequency-correction mechanisms can replace the default step with a separate compensation step:

- **Burst correction** applies the compensation step on a fixed number of consecutive ticks.
- **Slow correction** applies it on one tick out of every N ticks.

Software sets up the block through a word-addressed register port. That port holds the control fields, a sticky wrap flag, both correction counters and the two 32-bit halves of the time value.

Reading the time is tear-free. A read of the low half freezes a copy of the high half for the read that follows. Writing is also atomic: the high half is written first and only stored, and the whole 64-bit value is loaded when the low half is written. The live value and the wrap flag are also driven as ports. Compare logic elsewhere in the chip can force the time to zero through a wrap request.

Top module: `ns_time_counter`

## Requirements
- R1: When the enable bit (control bit 0, address 0) is clear, the time value holds, except for a low-half load or a wrap request.
- R2: When enabled, with no correction active, each tick adds the default step, taken from control bits [7:4].
- R3: Writing N to the burst register (address 2, 24 bits) makes the next N enabled ticks add the compensation step (control bits [19:8]). Each of those ticks decrements the register, which stops at 0.
- R4: Writing N>0 to the slow register (address 3) makes every N-th enabled tick add the compensation step, with the first such tick being the N-th one after the write. Writing 0 turns slow correction off.
- R5: A tick that has both corrections active adds the compensation step once.
- R6: A read of the low half (address 4) captures the high half at that moment. A later read of the high half (address 5) returns that captured value even after the live time has moved on.
- R7: Writing the high half changes nothing visible. Writing the low half then loads {stored high, written low} in one cycle.
- R8: A carry out of the 64-bit addition sets the wrap flag, which is status bit 0 at address 1.
- R9: A wrap request forces the time to 0 on the next edge and sets the wrap flag. It takes priority over a low-half load and over a tick.
- R10: The wrap flag stays set until a write to address 1 with bit 0 set. Writing 0 there leaves it set.
- R11: After reset, the time, the flag and the read data are 0. Read data appears on the cycle after the read strobe. The control, burst and slow registers read back their current values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one tick per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Word address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, valid one cycle after reg_rd |
| wrap_req | input | 1 | Force time to zero and set the wrap flag |
| count_o | output | CNT_W | Live time value in nanoseconds |
| ovf_o | output | 1 | Sticky wrap flag |

## Verification
Any wrong choice of step shows on count_o at the very next edge, as a difference from the expected per-tick delta. A burst or slow counter that is off by one shows up within the correction window as a total that is too large or too small. A stale or missing high-half snapshot is only seen on a high-half read made after the count crosses a 2^32 boundary, so the bench forces that crossing with a preload. A flag that fails to stay set, or fails to clear, shows on ovf_o one cycle after the status write.

// File: rtl/ns_time_counter.sv
module ns_time_counter #(
  parameter int CNT_W   = 64,
  parameter int DW      = 32,
  parameter int AW      = 3,
  parameter int DEF_W   = 4,
  parameter int COMP_W  = 12,
  parameter int BURST_W = 24,
  parameter int SLOW_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             wrap_req,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  localparam int HI_W     = CNT_W - DW;
  localparam int DEF_LSB  = 4;
  localparam int DEF_MSB  = DEF_LSB + DEF_W - 1;
  localparam int COMP_LSB = DEF_MSB + 1;
  localparam int COMP_MSB = COMP_LSB + COMP_W - 1;
  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_STAT  = AW'(1);
  localparam logic [AW-1:0] A_BURST = AW'(2);
  localparam logic [AW-1:0] A_SLOW  = AW'(3);
  localparam logic [AW-1:0] A_LO    = AW'(4);
  localparam logic [AW-1:0] A_HI    = AW'(5);

  logic               en;
  logic [DEF_W-1:0]   def_inc;
  logic [COMP_W-1:0]  comp_inc;
  logic [BURST_W-1:0] burst_cnt;
  logic [SLOW_W-1:0]  slow_reload, slow_cnt;
  logic [HI_W-1:0]    hi_stage, hi_snap;
  logic [CNT_W-1:0]   count, step;
  logic [CNT_W:0]     sum;
  logic [DW-1:0]      ctrl_word;
  logic               slow_hit, use_comp;

  wire wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  wire wr_stat  = reg_wr && (reg_addr == A_STAT);
  wire wr_burst = reg_wr && (reg_addr == A_BURST);
  wire wr_slow  = reg_wr && (reg_addr == A_SLOW);
  wire wr_lo    = reg_wr && (reg_addr == A_LO);
  wire wr_hi    = reg_wr && (reg_addr == A_HI);
  wire tick     = en && !wrap_req && !wr_lo;

  assign slow_hit = en && (slow_reload != '0) && (slow_cnt == '0);
  assign use_comp = (burst_cnt != '0) || slow_hit;
  assign step     = use_comp ? CNT_W'(comp_inc) : CNT_W'(def_inc);
  assign sum      = {1'b0, count} + {1'b0, step};
  assign count_o  = count;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[0] = en;
    ctrl_word[DEF_MSB:DEF_LSB] = def_inc;
    ctrl_word[COMP_MSB:COMP_LSB] = comp_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0;
      def_inc <= '0;
      comp_inc <= '0;
      hi_stage <= '0;
    end else begin
      if (wr_ctrl) begin
        en <= reg_wdata[0];
        def_inc <= reg_wdata[DEF_MSB:DEF_LSB];
        comp_inc <= reg_wdata[COMP_MSB:COMP_LSB];
      end
      if (wr_hi) hi_stage <= reg_wdata[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (wrap_req)   count <= '0;
      else if (wr_lo) count <= {hi_stage, reg_wdata};
      else if (en)    count <= sum[CNT_W-1:0];
      if (wrap_req || (tick && sum[CNT_W])) ovf_o <= 1'b1;
      else if (wr_stat && reg_wdata[0])     ovf_o <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) burst_cnt <= '0;
    else if (wr_burst) burst_cnt <= reg_wdata[BURST_W-1:0];
    else if (en && burst_cnt != '0) burst_cnt <= burst_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_reload <= '0;
      slow_cnt <= '0;
    end else if (wr_slow) begin
      slow_reload <= reg_wdata[SLOW_W-1:0];
      slow_cnt <= (reg_wdata[SLOW_W-1:0] == '0) ? '0 : reg_wdata[SLOW_W-1:0] - 1'b1;
    end else if (en && slow_reload != '0) begin
      slow_cnt <= (slow_cnt == '0) ? slow_reload - 1'b1 : slow_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      hi_snap <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_CTRL:  reg_rdata <= ctrl_word;
        A_STAT:  reg_rdata <= DW'(ovf_o);
        A_BURST: reg_rdata <= DW'(burst_cnt);
        A_SLOW:  reg_rdata <= DW'(slow_reload);
        A_LO: begin
          reg_rdata <= count[DW-1:0];
          hi_snap <= count[CNT_W-1:DW];
        end
        A_HI:    reg_rdata <= DW'(hi_snap);
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ns_time_counter_chk.sv
module ns_time_counter_chk #(
  parameter int CNT_W   = 64,
  parameter int DW      = 32,
  parameter int AW      = 3,
  parameter int DEF_W   = 4,
  parameter int BURST_W = 24,
  parameter int SLOW_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [AW-1:0]      reg_addr,
  input logic [DW-1:0]      reg_wdata,
  input logic               wrap_req,
  input logic [CNT_W-1:0]   count_o,
  input logic               ovf_o,
  input logic               en,
  input logic [DEF_W-1:0]   def_inc,
  input logic [BURST_W-1:0] burst_cnt,
  input logic [SLOW_W-1:0]  slow_reload,
  input logic [CNT_W-DW-1:0] hi_stage
);
  localparam logic [AW-1:0] A_STAT  = AW'(1);
  localparam logic [AW-1:0] A_BURST = AW'(2);
  localparam logic [AW-1:0] A_LO    = AW'(4);

  wire wr_lo    = reg_wr && reg_addr == A_LO;
  wire wr_burst = reg_wr && reg_addr == A_BURST;
  wire clr_ovf  = reg_wr && reg_addr == A_STAT && reg_wdata[0];

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wrap_req && !wr_lo) |=> $stable(count_o)); // R1
  AST_DEFAULT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap_req && !wr_lo && burst_cnt == '0 && slow_reload == '0)
      |=> count_o == $past(count_o) + CNT_W'($past(def_inc))); // R2
  AST_BURST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && burst_cnt != '0 && !wr_burst) |=> burst_cnt == $past(burst_cnt) - 1'b1); // R3
  AST_LOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wrap_req) |=> count_o == {$past(hi_stage), $past(reg_wdata)}); // R7
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_req |=> (count_o == '0 && ovf_o)); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !clr_ovf) |=> ovf_o); // R10
endmodule

bind ns_time_counter ns_time_counter_chk #(
  .CNT_W(CNT_W), .DW(DW), .AW(AW), .DEF_W(DEF_W), .BURST_W(BURST_W), .SLOW_W(SLOW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .wrap_req(wrap_req), .count_o(count_o), .ovf_o(ovf_o), .en(en), .def_inc(def_inc),
  .burst_cnt(burst_cnt), .slow_reload(slow_reload), .hi_stage(hi_stage)
);

// File: tb/ns_time_counter_test.sv
module ns_time_counter_test;
  localparam int PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, wrap_req = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] count_o;
  logic ovf_o;
  int checks = 0, errors = 0;
  bit done = 0;

  ns_time_counter uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wrap_req(wrap_req),
    .count_o(count_o), .ovf_o(ovf_o));

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl(input bit e, input int d, input int c);
    return {12'h0, c[11:0], d[3:0], 3'b000, e};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic t_reset;
    check("R11 reset count", count_o, 0);
    check("R11 reset flag", 64'(ovf_o), 0);
    check("R11 reset rdata", 64'(reg_rdata), 0);
  endtask

  task automatic t_default;
    logic [63:0] c0;
    wr(0, ctrl(1, 5, 0));
    c0 = count_o;
    repeat (10) @(negedge clk);
    check("R2 default step", count_o, c0 + 50);
    wr(0, ctrl(0, 5, 0));
    c0 = count_o;
    repeat (5) @(negedge clk);
    check("R1 hold when off", count_o, c0);
  endtask

  task automatic t_burst;
    logic [63:0] c0;
    logic [31:0] d;
    wr(2, 4);
    wr(0, ctrl(1, 2, 9));
    c0 = count_o;
    repeat (10) @(negedge clk);
    check("R3 burst total", count_o, c0 + 4*9 + 6*2);
    wr(0, ctrl(0, 2, 9));
    rd(2, d);
    check("R3 burst drained", 64'(d), 0);
  endtask

  task automatic t_slow;
    logic [63:0] c0;
    wr(3, 3);
    wr(0, ctrl(1, 1, 11));
    c0 = count_o;
    repeat (9) @(negedge clk);
    check("R4 slow every third", count_o, c0 + 3*11 + 6);
    wr(0, ctrl(0, 1, 11));
    wr(3, 0);
    wr(0, ctrl(1, 1, 11));
    c0 = count_o;
    repeat (6) @(negedge clk);
    check("R4 slow off", count_o, c0 + 6);
    wr(0, ctrl(0, 1, 11));
  endtask

  task automatic t_both;
    logic [63:0] c0;
    wr(2, 2);
    wr(3, 1);
    wr(0, ctrl(1, 1, 7));
    c0 = count_o;
    repeat (4) @(negedge clk);
    check("R5 single comp step", count_o, c0 + 28);
    wr(0, ctrl(0, 1, 7));
    wr(3, 0);
  endtask

  task automatic t_split;
    logic [63:0] c0;
    logic [31:0] d;
    c0 = count_o;
    wr(5, 1);
    check("R7 high write invisible", count_o, c0);
    wr(4, 32'hFFFF_FFF0);
    check("R7 atomic load", count_o, 64'h1_FFFF_FFF0);
    rd(4, d);
    check("R6 low read", 64'(d), 64'hFFFF_FFF0);
    wr(0, ctrl(1, 8, 0));
    repeat (3) @(negedge clk);
    check("R6 live high moved", 64'(count_o[63:32]), 2);
    rd(5, d);
    check("R6 snapshot high", 64'(d), 1);
    rd(4, d);
    rd(5, d);
    check("R6 new snapshot", 64'(d), 2);
    wr(0, ctrl(0, 8, 0));
  endtask

  task automatic t_ovf;
    logic [31:0] d;
    wr(5, 32'hFFFF_FFFF);
    wr(4, 32'hFFFF_FFFC);
    wr(0, ctrl(1, 4, 0));
    check("R8 no flag before carry", 64'(ovf_o), 0);
    @(negedge clk);
    check("R8 wrapped value", count_o, 0);
    check("R8 flag on carry", 64'(ovf_o), 1);
    wr(0, ctrl(0, 4, 0));
    rd(1, d);
    check("R8 status read", 64'(d), 1);
    wr(1, 0);
    check("R10 zero write keeps flag", 64'(ovf_o), 1);
    wr(1, 1);
    check("R10 one write clears", 64'(ovf_o), 0);
  endtask

  task automatic t_wrap;
    wr(0, ctrl(1, 2, 0));
    repeat (2) @(negedge clk);
    wrap_req = 1; reg_wr = 1; reg_addr = 4; reg_wdata = 32'h1234;
    @(negedge clk);
    wrap_req = 0; reg_wr = 0;
    check("R9 forced zero", count_o, 0);
    check("R9 flag set", 64'(ovf_o), 1);
    @(negedge clk);
    check("R9 resumes", count_o, 2);
    wr(0, ctrl(0, 2, 0));
    wr(1, 1);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(0, ctrl(0, 7, 12'hABC));
    rd(0, d);
    check("R11 control readback", 64'(d), 64'h000A_BC70);
    wr(2, 32'h0012_3456);
    rd(2, d);
    check("R11 burst readback", 64'(d), 64'h12_3456);
    wr(2, 0);
    wr(3, 5);
    rd(3, d);
    check("R11 slow readback", 64'(d), 5);
    wr(3, 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_default;
    t_burst;
    t_slow;
    t_both;
    t_split;
    t_ovf;
    t_wrap;
    t_regs;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule